// File: doc/BRIEF.md
# Dual-Output Pulse-Width Generator

This block produces two pulse-width modulated outputs, A and B, from one shared time base. The input clock first passes through a prescaler. The prescaler divides by the product of a power-of-two factor and an even-step factor. Each prescaler tick advances an up-counter that runs from zero to a programmable period and then wraps to zero. Because both outputs use this one counter, they always run at the same frequency.

Every tick raises up to four events: counter at zero, counter at period, counter matching threshold A and counter matching threshold B. A per-output action word maps each event to no action, clear, set or toggle, so each output can have its own duty cycle.

Configuration arrives through a single-cycle write strobe with an address and a data word. Period and threshold writes are staged and take effect only when the counter wraps, so a running waveform never sees a half-updated cycle. An enable input runs the time base; while it is low the time base freezes and both outputs are held low.

Top module: `pwm2_top`

## Requirements
- R1: The time base advances once every N enabled input clocks. N is the coarse factor 2^c (c = data bits [2:0] of address 0) multiplied by the fine factor F, where F is 1 for a fine code f of 0 and 2*f otherwise (f = data bits [5:3] of address 0). A prescale write takes effect on the next clock.
- R2: After reset the divide factor is 1, the staged and active period and both thresholds are 0, both action words are 0, and both outputs are low.
- R3: On each tick the counter goes up by one. On a tick where it equals the active period it returns to 0 instead. It never exceeds the active period.
- R4: Writes to the period (address 1), threshold A (address 2) and threshold B (address 3) go to staging registers. These are copied into the active registers only on the tick where the counter wraps from the period to 0.
- R5: Action words (address 4 for output A, address 5 for output B) take effect at once. Bits [1:0] act on the zero event, [3:2] on the period event, [5:4] on the threshold A event and [7:6] on the threshold B event. The codes are 0 = none, 1 = clear, 2 = set, 3 = toggle. An output changes at the clock edge that ends the tick.
- R6: When several events fire on one tick, the output applies the action of the first event with a non-zero action, in the order threshold A, threshold B, period, zero.
- R7: While enable is low, the prescaler and counter hold their values and both outputs are driven low from the next clock edge.
- R8: With coarse code 3 and fine code 2, the time base ticks exactly once every 32 input clocks.
- R9: Both outputs share one counter and period, while each output follows its own action word.
- R10: Writes to addresses 6 and 7 change nothing observable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the time base when high; freezes it and holds the outputs low when low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | W | Write data |
| out_a | output | 1 | Pulse output A |
| out_b | output | 1 | Pulse output B |

## Verification
The bench targets four corner cases:

- **Period of zero.** Zero and period events fire on every tick. A design that mis-ranks its events would show the zero action instead of the period action.
- **Coincident events.** Threshold values equal to 0 or to the period make threshold, period and zero events land on one tick. A wrong priority order or a dropped action leaves an output at the wrong level.
- **Mid-cycle writes.** Writes to the period and thresholds arrive in the middle of a cycle. A design without staging would shorten or stretch the running cycle, or skip a match.
- **Prescale and enable timing.** Prescale changes, the 32-clock case and enable drops are all checked. A wrong fine-factor encoding, or a prescaler that keeps counting while disabled, shifts every later edge.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    logic thr_b;
    logic thr_a;
    logic prd;
    logic zero;
  } evt_t;

  // Divide factor: power-of-two coarse part times even-step fine part.
  function automatic int unsigned prescale_factor(logic [2:0] coarse, logic [2:0] fine);
    int unsigned f;
    f = (fine == 3'd0) ? 1 : 2 * int'(fine);
    return (32'd1 << coarse) * f;
  endfunction

  // Highest-ranked fired event with a non-zero action wins.
  function automatic act_e pick_act(evt_t ev, logic [7:0] ctl);
    act_e r;
    r = ACT_NONE;
    if (ev.zero  && ctl[1:0] != 2'd0) r = act_e'(ctl[1:0]);
    if (ev.prd   && ctl[3:2] != 2'd0) r = act_e'(ctl[3:2]);
    if (ev.thr_b && ctl[7:6] != 2'd0) r = act_e'(ctl[7:6]);
    if (ev.thr_a && ctl[5:4] != 2'd0) r = act_e'(ctl[5:4]);
    return r;
  endfunction

  function automatic logic apply_act(logic cur, act_e a);
    case (a)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int DIV_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] coarse,
  input  logic [2:0] fine,
  output logic       tick
);
  import pwm2_pkg::*;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] lim;

  assign lim  = DIV_W'(prescale_factor(coarse, fine) - 1);
  assign tick = en && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (en) begin
      if (pre_q >= lim) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
    end
  end

  // R7
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pre_q));

endmodule

// File: rtl/pwm2_timebase.sv
module pwm2_timebase
  import pwm2_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] stg_prd,
  input  logic [W-1:0] stg_thr_a,
  input  logic [W-1:0] stg_thr_b,
  output evt_t         ev
);

  logic [W-1:0] cnt_q, prd_q, thr_a_q, thr_b_q;
  logic         wrap;

  assign wrap     = tick && (cnt_q == prd_q);
  assign ev.zero  = tick && (cnt_q == '0);
  assign ev.prd   = wrap;
  assign ev.thr_a = tick && (cnt_q == thr_a_q);
  assign ev.thr_b = tick && (cnt_q == thr_b_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prd_q   <= '0;
      thr_a_q <= '0;
      thr_b_q <= '0;
    end else if (wrap) begin
      cnt_q   <= '0;
      prd_q   <= stg_prd;
      thr_a_q <= stg_thr_a;
      thr_b_q <= stg_thr_b;
    end else if (tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_q);
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(prd_q) && $stable(thr_a_q) && $stable(thr_b_q)));
  // R7
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/pwm2_aq.sv
module pwm2_aq
  import pwm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  evt_t       ev,
  input  logic [7:0] ctl,
  output logic       out
);

  act_e act;
  assign act = pick_act(ev, ctl);

  always_ff @(posedge clk) begin
    if (!rst_n)   out <= 1'b0;
    else if (!en) out <= 1'b0;
    else          out <= apply_act(out, act);
  end

  // R5
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev == '0) |=> $stable(out));
  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out);

endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
  import pwm2_pkg::*;
#(
  parameter int W     = 16,
  parameter int NCH   = 2,
  parameter int DIV_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         out_a,
  output logic         out_b
);

  localparam logic [2:0] A_PRESC = 3'd0;
  localparam logic [2:0] A_PRD   = 3'd1;
  localparam logic [2:0] A_THRA  = 3'd2;
  localparam logic [2:0] A_THRB  = 3'd3;
  localparam logic [2:0] A_CTL0  = 3'd4;

  logic [5:0]   presc_q;
  logic [W-1:0] stg_prd, stg_thr_a, stg_thr_b;
  logic [7:0]   ctl_q [NCH];
  logic [NCH-1:0] outs;
  logic         tb_tick;
  evt_t         ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q   <= '0;
      stg_prd   <= '0;
      stg_thr_a <= '0;
      stg_thr_b <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PRESC: presc_q   <= wr_data[5:0];
        A_PRD:   stg_prd   <= wr_data;
        A_THRA:  stg_thr_a <= wr_data;
        A_THRB:  stg_thr_b <= wr_data;
        default: ;
      endcase
    end
  end

  pwm2_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en),
    .coarse(presc_q[2:0]), .fine(presc_q[5:3]), .tick(tb_tick)
  );

  pwm2_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick),
    .stg_prd(stg_prd), .stg_thr_a(stg_thr_a), .stg_thr_b(stg_thr_b),
    .ev(ev)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) ctl_q[ch] <= '0;
      else if (wr_en && wr_addr == A_CTL0 + 3'(ch)) ctl_q[ch] <= wr_data[7:0];
    end

    pwm2_aq u_aq (
      .clk(clk), .rst_n(rst_n), .en(en),
      .ev(ev), .ctl(ctl_q[ch]), .out(outs[ch])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];

endmodule

// File: tb/pwm2_top_bench.sv
module pwm2_top_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic out_a, out_b;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit model_on = 0;
  bit done = 0;
  string cur_req = "R2";

  // model state
  int m_pre, m_cnt, m_prd, m_ta, m_tb, s_prd, s_ta, s_tb, m_presc;
  int m_ctl [2];
  bit m_out [2];

  pwm2_top u_pwm2_top (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
  );

  always #4 clk = ~clk;

  function automatic int b_div(int code);
    int c, f, p, fine_f;
    c = code & 7;
    f = (code >> 3) & 7;
    p = 1;
    for (int i = 0; i < c; i++) p = p + p;
    case (f)
      0: fine_f = 1;  1: fine_f = 2;  2: fine_f = 4;  3: fine_f = 6;
      4: fine_f = 8;  5: fine_f = 10; 6: fine_f = 12; default: fine_f = 14;
    endcase
    return p * fine_f;
  endfunction

  function automatic bit b_act(bit cur, int ctl, bit z, bit p, bit a, bit b);
    int sel;
    int code;
    sel = -1;
    // ranking: threshold A, threshold B, period, zero
    if (a && ((ctl >> 4) & 3) != 0) sel = 4;
    else if (b && ((ctl >> 6) & 3) != 0) sel = 6;
    else if (p && ((ctl >> 2) & 3) != 0) sel = 2;
    else if (z && (ctl & 3) != 0) sel = 0;
    if (sel < 0) return cur;
    code = (ctl >> sel) & 3;
    if (code == 1) return 1'b0;
    if (code == 2) return 1'b1;
    return ~cur;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_prd = 0; m_ta = 0; m_tb = 0;
      s_prd = 0; s_ta = 0; s_tb = 0; m_presc = 0;
      m_ctl[0] = 0; m_ctl[1] = 0; m_out[0] = 0; m_out[1] = 0;
    end else begin
      bit t, z, p, a, b;
      t = en && (m_pre >= b_div(m_presc) - 1);
      z = t && m_cnt == 0;
      p = t && m_cnt == m_prd;
      a = t && m_cnt == m_ta;
      b = t && m_cnt == m_tb;
      for (int ch = 0; ch < 2; ch++)
        m_out[ch] = en ? b_act(m_out[ch], m_ctl[ch], z, p, a, b) : 1'b0;
      if (en) m_pre = t ? 0 : m_pre + 1;
      if (p) begin
        m_cnt = 0; m_prd = s_prd; m_ta = s_ta; m_tb = s_tb;
      end else if (t) m_cnt = m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_presc = int'(wr_data) & 63;
          3'd1: s_prd = int'(wr_data);
          3'd2: s_ta = int'(wr_data);
          3'd3: s_tb = int'(wr_data);
          3'd4: m_ctl[0] = int'(wr_data) & 255;
          3'd5: m_ctl[1] = int'(wr_data) & 255;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(cur_req, {30'd0, out_b, out_a}, {30'd0, m_out[1], m_out[0]});
    end
  end

  task automatic wr(int addr, int data);
    wr_en = 1'b1;
    wr_addr = 3'(addr);
    wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    en = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    model_on = 1;
    // R2: reset state, defaults produce no activity
    chk("R2", {30'd0, out_b, out_a}, 0);
    en = 1'b1;
    idle(20);
    chk("R2", {30'd0, out_b, out_a}, 0);

    // R10: address map; stray addresses inert
    cur_req = "R10";
    en = 1'b0;
    wr(6, 16'hffff);
    wr(7, 16'hffff);
    wr(4, 2);          // A: set on zero
    en = 1'b1;
    idle(3);
    chk("R10", out_a, 1);
    chk("R10", out_b, 0);

    // R6: coincident events with period 0 and thresholds 0
    cur_req = "R6";
    do_reset();
    wr(4, 16'h12);     // A: zero set, thr A clear -> stays low
    wr(5, 16'h06);     // B: zero set, period clear -> stays low
    en = 1'b1;
    idle(10);
    chk("R6", out_a, 0);
    chk("R6", out_b, 0);
    wr(5, 16'h0b);     // B: zero toggle, period set -> high
    idle(3);
    chk("R6", out_b, 1);

    // R8: coarse 3, fine 2 -> 32 clocks per tick
    cur_req = "R8";
    do_reset();
    wr(0, (2 << 3) | 3);
    wr(4, 3);          // A: toggle on zero, period 0 -> toggles every tick
    en = 1'b1;
    begin
      int t0, t1, lim;
      bit prev;
      prev = out_a;
      lim = 0;
      while (out_a == prev && lim < 200) begin @(negedge clk); lim++; end
      t0 = cyc;
      prev = out_a;
      lim = 0;
      while (out_a == prev && lim < 200) begin @(negedge clk); lim++; end
      t1 = cyc;
      chk("R8", t1 - t0, 32);
    end

    // R4: staged period/threshold writes mid-cycle
    cur_req = "R4";
    do_reset();
    wr(1, 9);
    wr(2, 4);
    wr(3, 7);
    wr(4, 16'h0012 | 16'h0000);  // A: set zero, clear thrA
    wr(5, 16'h0042);             // B: set zero, clear thrB
    en = 1'b1;
    idle(25);
    wr(1, 3);
    wr(2, 1);
    idle(40);

    // R7: enable drop holds time base, outputs low
    cur_req = "R7";
    en = 1'b0;
    @(negedge clk);
    chk("R7", {30'd0, out_b, out_a}, 0);
    idle(7);
    en = 1'b1;
    idle(30);

    // R1 / R3 / R5 / R9: constrained random traffic
    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: cur_req = "R1";
        1: cur_req = "R3";
        2: cur_req = "R5";
        default: cur_req = "R9";
      endcase
      do_reset();
      en = 1'b1;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(7) == 0) begin
          int ad;
          int dt;
          ad = int'($urandom_range(7));
          case (ad)
            0: dt = (int'($urandom_range(3)) << 3) | int'($urandom_range(2));
            1: dt = int'($urandom_range(12));
            2, 3: dt = int'($urandom_range(14));
            default: dt = int'($urandom_range(255));
          endcase
          wr(ad, dt);
        end else begin
          if ($urandom_range(63) == 0) en = ~en;
          @(negedge clk);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule